// File: doc/BRIEF.md
# Chip-Select-Gated Configurable Command Register

A one-stage register sitting on the command/address path between a memory controller and the memory devices of a module. On every rising clock edge it captures a data word together with a registered copy of the chip-select input. Two static configuration pins choose the layout: a 25-bit single-copy register, or a 14-bit register whose outputs are fanned out to an A copy and a B copy, with the clock-enable and termination bits placed at front-side or back-side positions.

The ordinary data bits are suspended (they keep their value) when both the chip-select input and its qualifier are high at the edge; the clock-enable and termination bits and the registered chip-select keep loading regardless. An active-low reset, asynchronous to the clock, clears all state and drives every output low at once.

Top module: `cs_gated_regbuf`

## Requirements
- R1: Data on `d_in` is registered on the rising edge of `clk` and appears on `q_a` after that edge.
- R2: The mode is taken from `{cfg_dup, cfg_back}`: 2'b00 is 25-bit single copy, 2'b10 is 14-bit dual copy front placement, 2'b11 is 14-bit dual copy back placement, 2'b01 is reserved.
- R3: When `sel_in` and `sel_qual` are both high at an edge, every ordinary data bit of the register keeps its previous value.
- R4: When either `sel_in` or `sel_qual` is low at an edge, all bits of the active width load from `d_in`.
- R5: `q_sel_a` takes the value of `sel_in` on every edge in any non-reserved mode, including edges where data is suspended.
- R6: The clock-enable and termination bits load on every edge regardless of gating; they sit at bit indices 0 and 3 in single-copy and front modes, and at indices 13 and 10 in back mode.
- R7: While `rst_n` is low, all outputs are low, without waiting for a clock edge.
- R8: In both dual-copy modes `q_b` equals `q_a[13:0]`, `q_sel_b` equals `q_sel_a`, and `q_a[24:14]` are low.
- R9: In the reserved mode all data and select outputs are low and `cfg_error` is high; in other modes `cfg_error` is low.
- R10: In single-copy mode `q_b` and `q_sel_b` are low.
- R11: A change on the configuration pins takes effect at the next rising edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dup | input | 1 | Configuration: 1 selects dual-copy 14-bit layout |
| cfg_back | input | 1 | Configuration: back placement in dual-copy layout |
| d_in | input | 25 | Data, clock-enable and termination inputs |
| sel_in | input | 1 | Chip-select input, registered and used for gating |
| sel_qual | input | 1 | Chip-select qualifier for gating |
| q_a | output | 25 | Registered outputs, A copy / single-copy outputs |
| q_b | output | 14 | Registered outputs, B copy in dual-copy modes |
| q_sel_a | output | 1 | Registered chip-select, A copy |
| q_sel_b | output | 1 | Registered chip-select, B copy |
| cfg_error | output | 1 | High while the reserved configuration is in force |

## Verification
The bench builds the block with its defaults: a 25-bit wide register, a 14-bit narrow layout, and control-bit positions 0 and 3 for front placement and 13 and 10 for back placement. These values make both control-bit placements reachable from the same input vector, so a suspended cycle in front mode and one in back mode expose different held and loaded bits. The 14-bit narrow width lets the tests confirm that the upper eleven A outputs are forced low while the B copy mirrors the lower fourteen.

// File: rtl/cs_gated_regbuf.sv
module cs_gated_regbuf #(
  parameter int DW    = 25,
  parameter int NW    = 14,
  parameter int CKE_F = 0,
  parameter int ODT_F = 3,
  parameter int CKE_K = 13,
  parameter int ODT_K = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dup,
  input  logic          cfg_back,
  input  logic [DW-1:0] d_in,
  input  logic          sel_in,
  input  logic          sel_qual,
  output logic [DW-1:0] q_a,
  output logic [NW-1:0] q_b,
  output logic          q_sel_a,
  output logic          q_sel_b,
  output logic          cfg_error
);

  typedef enum logic [1:0] {
    M_SINGLE = 2'b00,
    M_RSVD   = 2'b01,
    M_FRONT  = 2'b10,
    M_BACK   = 2'b11
  } mode_t;

  localparam logic [DW-1:0] ONE       = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] NARROW    = {{(DW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [DW-1:0] CTL_FRONT = (ONE << CKE_F) | (ONE << ODT_F);
  localparam logic [DW-1:0] CTL_BACK  = (ONE << CKE_K) | (ONE << ODT_K);

  function automatic logic [DW-1:0] ctl_of(input mode_t m);
    return (m == M_BACK) ? CTL_BACK : CTL_FRONT;
  endfunction

  function automatic logic [DW-1:0] width_of(input mode_t m);
    case (m)
      M_SINGLE: return '1;
      M_FRONT,
      M_BACK:   return NARROW;
      default:  return '0;
    endcase
  endfunction

  mode_t         mode_nx, mode_r;
  logic [DW-1:0] data_r, load_mask, ctl_cur;
  logic          sel_r, suspend, dual;

  assign mode_nx   = mode_t'({cfg_dup, cfg_back});
  assign suspend   = sel_in & sel_qual;
  assign load_mask = suspend ? ctl_of(mode_nx) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= M_SINGLE;
      data_r <= '0;
      sel_r  <= 1'b0;
    end else begin
      mode_r <= mode_nx;
      if (mode_nx == M_RSVD) begin
        data_r <= '0;
        sel_r  <= 1'b0;
      end else begin
        data_r <= (data_r & ~load_mask) | (d_in & load_mask);
        sel_r  <= sel_in;
      end
    end
  end

  assign dual      = (mode_r == M_FRONT) || (mode_r == M_BACK);
  assign ctl_cur   = ctl_of(mode_r);
  assign q_a       = data_r & width_of(mode_r);
  assign q_b       = dual ? data_r[NW-1:0] : '0;
  assign q_sel_a   = (mode_r != M_RSVD) & sel_r;
  assign q_sel_b   = dual & sel_r;
  assign cfg_error = (mode_r == M_RSVD);

  // R3: suspended edge in a stable non-reserved mode leaves ordinary bits untouched
  a_r3_hold_when_suspended: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && mode_nx == mode_r && mode_r != M_RSVD)
      |=> ((q_a & ~ctl_cur) == $past(q_a & ~ctl_cur)));

  // R5: registered select follows the pin on every non-reserved edge
  a_r5_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_nx != M_RSVD) |=> (q_sel_a == $past(sel_in)));

  // R8: dual-copy outputs mirror each other, upper A bits low
  a_r8_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> (q_b == q_a[NW-1:0] && q_sel_b == q_sel_a && (q_a & ~NARROW) == '0));

  // R9: reserved mode drives everything low with the flag up
  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (q_a == '0 && q_b == '0 && !q_sel_a && !q_sel_b));

  // R10: single-copy mode leaves the B copy idle
  a_r10_single_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == M_SINGLE) |-> (q_b == '0 && !q_sel_b));

  // R7: held reset keeps every output low
  always @(negedge clk) begin
    if (rst_n === 1'b0)
      a_r7_reset_low: assert (q_a == '0 && q_b == '0 && !q_sel_a && !q_sel_b && !cfg_error);
  end

endmodule

// File: tb/cs_gated_regbuf_test.sv
`timescale 1ns/1ps
module cs_gated_regbuf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dup = 1'b0, cfg_back = 1'b0;
  logic [24:0] d_in = '0;
  logic        sel_in = 1'b0, sel_qual = 1'b0;
  logic [24:0] q_a;
  logic [13:0] q_b;
  logic        q_sel_a, q_sel_b, cfg_error;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cs_gated_regbuf uut (
    .clk(clk), .rst_n(rst_n), .cfg_dup(cfg_dup), .cfg_back(cfg_back),
    .d_in(d_in), .sel_in(sel_in), .sel_qual(sel_qual),
    .q_a(q_a), .q_b(q_b), .q_sel_a(q_sel_a), .q_sel_b(q_sel_b),
    .cfg_error(cfg_error)
  );

  task automatic chk(input string req, input logic [24:0] act, input logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R7 reset q_a", q_a, '0);
    chk("R7 reset q_b", 25'(q_b), '0);
    chk("R7 reset sel/err", {22'd0, q_sel_a, q_sel_b, cfg_error}, '0);
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_single();
    cfg_dup = 0; cfg_back = 0; sel_in = 0; sel_qual = 0;
    d_in = 25'h1ABCDEF;
    step();
    chk("R1 capture", q_a, 25'h1ABCDEF);
    chk("R10 q_b idle", 25'(q_b), '0);
    chk("R10 q_sel_b idle", 25'(q_sel_b), '0);
    chk("R2 single no error", 25'(cfg_error), '0);
    sel_in = 1; sel_qual = 0; d_in = 25'h0123456;
    step();
    chk("R4 qual low loads", q_a, 25'h0123456);
    chk("R5 sel captured", 25'(q_sel_a), 25'd1);
  endtask

  task automatic t_gate_single();
    sel_in = 1; sel_qual = 1; d_in = 25'h1FFFFFF;
    step();
    chk("R3/R6 suspended single", q_a, 25'h012345F);
    chk("R5 sel not suspended", 25'(q_sel_a), 25'd1);
    sel_in = 0; sel_qual = 1; d_in = 25'h1FFFFFF;
    step();
    chk("R4 sel low loads", q_a, 25'h1FFFFFF);
    chk("R5 sel low captured", 25'(q_sel_a), '0);
  endtask

  task automatic t_front();
    cfg_dup = 1; cfg_back = 0; sel_in = 0; sel_qual = 0;
    d_in = 25'h1FF2A5C;
    step();
    chk("R8 front q_a", q_a, 25'h0002A5C);
    chk("R8 front q_b", 25'(q_b), 25'h0002A5C);
    chk("R8 front sel copies", {23'd0, q_sel_a, q_sel_b}, '0);
    sel_in = 1; sel_qual = 1; d_in = '0;
    step();
    chk("R6 front ctl bits load", q_a, 25'h0002A54);
    chk("R8 front q_b gated", 25'(q_b), 25'h0002A54);
    chk("R5 front sel copies", {23'd0, q_sel_a, q_sel_b}, 25'd3);
  endtask

  task automatic t_back();
    cfg_dup = 1; cfg_back = 1; sel_in = 0; sel_qual = 0;
    d_in = 25'h0003FFF;
    step();
    chk("R2 back load", q_a, 25'h0003FFF);
    sel_in = 1; sel_qual = 1; d_in = '0;
    step();
    chk("R6 back ctl bits 13,10 load", q_a, 25'h0001BFF);
    chk("R8 back q_b", 25'(q_b), 25'h0001BFF);
  endtask

  task automatic t_reserved();
    cfg_dup = 0; cfg_back = 1; sel_in = 1; sel_qual = 0; d_in = 25'h1555555;
    #1;
    chk("R11 no change before edge", q_a, 25'h0001BFF);
    chk("R11 no error before edge", 25'(cfg_error), '0);
    step();
    chk("R9 error flag", 25'(cfg_error), 25'd1);
    chk("R9 q_a low", q_a, '0);
    chk("R9 others low", {11'd0, q_b, q_sel_a, q_sel_b}, '0);
    cfg_dup = 0; cfg_back = 0; sel_in = 0; d_in = 25'h0000005;
    step();
    chk("R9 error clears", 25'(cfg_error), '0);
    chk("R2 back to single", q_a, 25'h0000005);
  endtask

  task automatic t_async();
    rst_n = 1'b0;
    #0.5;
    chk("R7 async clear q_a", q_a, '0);
    chk("R7 async clear flags", {23'd0, q_sel_a, cfg_error}, '0);
    step();
    rst_n = 1'b1;
    d_in = 25'h0000A0A;
    step();
    chk("R1 after reset", q_a, 25'h0000A0A);
  endtask

  initial begin
    t_reset();
    t_single();
    t_gate_single();
    t_front();
    t_back();
    t_reserved();
    t_async();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule